// File: doc/BRIEF.md
# Latched one-of-sixteen line decoder and demultiplexer

This block turns a 4-bit binary select code into a single active line out of sixteen. The code passes through a strobed address latch first. While the strobe is high the latch is transparent and the lines follow the select inputs with no delay. While the strobe is low the lines keep showing the code captured at the last clock edge on which the strobe was high. An active-low enable gates the output, and it does not pass through the latch.

Because the enable acts directly on the lines, a caller can hold an address and feed a serial bit stream into the enable. The block then works as a 1-to-16 demultiplexer: the addressed line carries the stream and all other lines stay idle. Several instances can share one select bus and use their enables as chip selects to build a wider decode. A parameter sets the polarity of the lines: active-high, or active-low where idle lines sit at 1.

Top module: `dec_latched_demux`

## Requirements
- R1: While strobe_i is 1, line_o decodes the current sel_i in the same cycle, with no register in the path.
- R2: While strobe_i is 0, line_o decodes the address captured at the last rising clock edge on which strobe_i was 1, and changes on sel_i have no effect.
- R3: While en_n_i is 1, every line sits at its inactive level, whatever the address.
- R4: The code is binary with sel_i[3] as the MSB, and code k selects line_o[k] for k from 0 to 15.
- R5: With POLARITY = POL_HIGH the selected line is 1, the other lines are 0, and a disabled block drives all lines 0. With POL_LOW every level is inverted: selected line 0, others 1, disabled all 1.
- R6: With the address held, the selected line follows the serial data applied to en_n_i (inverted for POL_HIGH, as-is for POL_LOW), and all other lines stay inactive.
- R7: en_n_i acts combinationally and bypasses the latch, so toggling it while the strobe is low takes effect in the same cycle.
- R8: At most one line is active at any time, and none is active while en_n_i is 1.
- R9: A synchronous reset on rst_i clears the held address to 0000, so line 0 is selected after reset while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock that samples the address latch |
| rst_i | input | 1 | Synchronous reset, active high, clears the held address |
| strobe_i | input | 1 | 1 = latch transparent, 0 = hold the captured address |
| sel_i | input | 4 | Binary select code, bit 3 is the MSB |
| en_n_i | input | 1 | Active-low enable; also serves as demux data and chip select |
| line_o | output | 16 | Decoded lines in the configured polarity |

## Verification
On every clock edge the assertions check that at most one line is active and none while disabled, that a transparent strobe with the enable low decodes the live select code, that the lines stay still while the strobe remains low and the enable does not move, and that line 0 is selected right after reset. Only the bench's scenarios can show the full code-to-line mapping for both polarities, that a held address ignores every other select value, and that a serial stream on the enable appears on the held line bit by bit.

// File: rtl/dec_pkg.sv
package dec_pkg;
    typedef enum logic {
        POL_LOW  = 1'b0,
        POL_HIGH = 1'b1
    } pol_e;
endpackage

// File: rtl/dec_addr_hold.sv
// Strobed address holder: transparent while strobe is high, otherwise
// presents the code captured on the last clock edge with strobe high.
module dec_addr_hold #(
    parameter int SEL_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             strobe_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [SEL_W-1:0] addr_o
);
    typedef struct packed {
        logic [SEL_W-1:0] addr;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (strobe_i) begin
            st_d.addr = sel_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o = strobe_i ? sel_i : st_q.addr;
endmodule

// File: rtl/dec_onehot.sv
// Binary to one-hot decode, gated by the active-low enable.
module dec_onehot #(
    parameter int SEL_W = 4,
    parameter int OUT_N = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] addr_i,
    input  logic             en_n_i,
    output logic [OUT_N-1:0] hot_o
);
    for (genvar g = 0; g < OUT_N; g++) begin : g_line
        assign hot_o[g] = !en_n_i && (addr_i == SEL_W'(g));
    end
endmodule

// File: rtl/dec_polarity.sv
// Maps internal active-high lines to the configured output polarity.
module dec_polarity #(
    parameter int          OUT_N    = 16,
    parameter dec_pkg::pol_e POLARITY = dec_pkg::POL_HIGH
) (
    input  logic [OUT_N-1:0] hot_i,
    output logic [OUT_N-1:0] line_o
);
    if (POLARITY == dec_pkg::POL_HIGH) begin : g_high
        assign line_o = hot_i;
    end else begin : g_low
        assign line_o = ~hot_i;
    end
endmodule

// File: rtl/dec_latched_demux.sv
module dec_latched_demux #(
    parameter int            SEL_W    = 4,
    parameter dec_pkg::pol_e POLARITY = dec_pkg::POL_HIGH,
    localparam int           OUT_N    = 1 << SEL_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             strobe_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             en_n_i,
    output logic [OUT_N-1:0] line_o
);
    logic [SEL_W-1:0] addr_w;
    logic [OUT_N-1:0] hot_w;

    dec_addr_hold #(.SEL_W(SEL_W)) u_hold (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .strobe_i (strobe_i),
        .sel_i    (sel_i),
        .addr_o   (addr_w)
    );

    dec_onehot #(.SEL_W(SEL_W), .OUT_N(OUT_N)) u_dec (
        .addr_i (addr_w),
        .en_n_i (en_n_i),
        .hot_o  (hot_w)
    );

    dec_polarity #(.OUT_N(OUT_N), .POLARITY(POLARITY)) u_pol (
        .hot_i  (hot_w),
        .line_o (line_o)
    );
endmodule

// File: rtl/dec_latched_demux_chk.sv
module dec_latched_demux_chk #(
    parameter int            SEL_W    = 4,
    parameter dec_pkg::pol_e POLARITY = dec_pkg::POL_HIGH,
    localparam int           OUT_N    = 1 << SEL_W
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             strobe_i,
    input logic [SEL_W-1:0] sel_i,
    input logic             en_n_i,
    input logic [OUT_N-1:0] line_o
);
    logic [OUT_N-1:0] act;
    logic             seen_q;

    assign act = (POLARITY == dec_pkg::POL_HIGH) ? line_o : ~line_o;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= 1'b1;
        end
    end

    assert_single_line_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(act));

    assert_disabled_idle_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        en_n_i |-> (act == '0));

    assert_transparent_decode_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (strobe_i && !en_n_i) |-> (act == ({{(OUT_N-1){1'b0}}, 1'b1} << sel_i)));

    assert_hold_stable_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (seen_q && !strobe_i && !$past(strobe_i) && $stable(en_n_i)) |-> $stable(line_o));

    assert_reset_line0_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(rst_i) && !strobe_i && !en_n_i) |-> (act == {{(OUT_N-1){1'b0}}, 1'b1}));
endmodule

bind dec_latched_demux dec_latched_demux_chk #(.SEL_W(SEL_W), .POLARITY(POLARITY)) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .strobe_i (strobe_i),
    .sel_i    (sel_i),
    .en_n_i   (en_n_i),
    .line_o   (line_o)
);

// File: tb/dec_latched_demux_bench.sv
module dec_latched_demux_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strobe = 1'b0;
    logic [3:0]  sel = 4'd0;
    logic        en_n = 1'b0;
    logic [15:0] line_hi, line_lo;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    dec_latched_demux #(.SEL_W(4), .POLARITY(dec_pkg::POL_HIGH)) u_dec_latched_demux (
        .clk_i(clk), .rst_i(rst), .strobe_i(strobe), .sel_i(sel), .en_n_i(en_n), .line_o(line_hi));

    dec_latched_demux #(.SEL_W(4), .POLARITY(dec_pkg::POL_LOW)) u_dec_latched_demux_lo (
        .clk_i(clk), .rst_i(rst), .strobe_i(strobe), .sel_i(sel), .en_n_i(en_n), .line_o(line_lo));

    function automatic logic [15:0] expect_line(bit hi, bit dis, int code);
        logic [15:0] v;
        v = dis ? 16'h0000 : (16'h0001 << code);
        return hi ? v : ~v;
    endfunction

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp || $countones(exp ^ (exp[0] === got[0] ? 16'h0 : 16'h0)) > 16) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic check_both(string tag, bit dis, int code);
        logic [15:0] eh;
        logic [15:0] el;
        eh = expect_line(1'b1, dis, code);
        el = expect_line(1'b0, dis, code);
        check({tag, " hi"}, line_hi, eh);
        check({tag, " lo"}, line_lo, el);
        checks++;
        if ($countones(line_hi) > 1 || $countones(~line_lo) > 1) begin
            failures++;
            $display("FAIL R8 active count hi=%0d lo=%0d exp<=1",
                     $countones(line_hi), $countones(~line_lo));
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired got=timeout exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R9: reset with strobe low leaves address 0000 held
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1 check_both("R9 reset selects line0", 1'b0, 0);

        // R1 R4 R5: transparent sweep over all codes, both polarities
        @(negedge clk);
        strobe = 1'b1;
        for (int k = 0; k < 16; k++) begin
            sel = 4'(k);
            #1 check_both($sformatf("R1 R4 R5 code %0d", k), 1'b0, k);
            @(negedge clk);
        end

        // R3: disabled, every code gives the idle level
        en_n = 1'b1;
        for (int k = 0; k < 16; k++) begin
            sel = 4'(k);
            #1 check_both($sformatf("R3 disabled code %0d", k), 1'b1, k);
            @(negedge clk);
        end

        // R2: capture code 9, then drop strobe and move sel everywhere
        en_n = 1'b0;
        sel  = 4'd9;
        @(negedge clk);
        strobe = 1'b0;
        for (int k = 15; k >= 0; k--) begin
            sel = 4'(k);
            #1 check_both($sformatf("R2 hold 9 with sel %0d", k), 1'b0, 9);
            @(negedge clk);
        end

        // R6 R7: serial stream on enable during hold, mid-cycle toggles too
        for (int i = 0; i < 16; i++) begin
            logic [15:0] pat;
            pat  = 16'hB4D2;
            en_n = pat[i];
            sel  = 4'(i * 7);
            #1 check_both($sformatf("R6 R7 stream bit %0d", i), pat[i], 9);
            en_n = ~pat[i];
            #1 check_both($sformatf("R7 midcycle toggle %0d", i), ~pat[i], 9);
            @(negedge clk);
        end

        // R2: re-strobe captures a new code, then holds it
        en_n   = 1'b0;
        strobe = 1'b1;
        sel    = 4'd3;
        @(negedge clk);
        strobe = 1'b0;
        sel    = 4'd12;
        #1 check_both("R2 recapture 3", 1'b0, 3);
        @(negedge clk);
        #1 check_both("R2 recapture still 3", 1'b0, 3);

        // R9: reset in the middle of operation returns to line 0
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1 check_both("R9 reset again", 1'b0, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule